// File: doc/BRIEF.md
# Floating-Point to Unsigned Integer Converter

This block turns one floating-point operand, in either the 32-bit or the 64-bit binary interchange format, into an unsigned integer that is either 32 or 64 bits wide. It applies one of four rounding modes. It raises an invalid condition when the value cannot be represented, and an inexact condition when fraction bits are lost. Each condition has its own trap enable. A trapped condition produces a trap code in place of a destination write. An untrapped condition sets a sticky flag that stays set until reset.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream through one output register. The input is ready whenever the output register is empty, or when it is being emptied in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output register holds its contents unchanged and no new operation is accepted. A 32-bit operand occupies bits [31:0] of `in_operand`, and its upper bits are ignored. The integer result is right-aligned in `out_result`.

Top module: `f2u_convert`

## Requirements
- R1: An operation accepted on a rising edge (`in_valid && in_ready`) appears on the outputs right after that edge with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the result, the write strobe and the trap code hold steady.
- R2: If the unbiased exponent is above the destination width minus one, the operation is invalid. This includes infinities and NaNs, whose exponent field is all ones. A positive sign gives an all-ones result at the destination width, with the upper 32 bits zero for a 32-bit destination. A negative sign gives zero.
- R3: A negative operand with unbiased exponent zero or more gives zero and raises invalid. This applies even to exact values such as -1.0.
- R4: A positive in-range operand with no fraction bits converts exactly, with no condition raised. ±0.0 also converts to zero with no condition raised.
- R5: Rounding modes use the encoding 00 nearest-even, 01 toward zero, 10 toward +inf and 11 toward -inf. For an inexact in-range positive value, toward +inf adds one, and toward zero and toward -inf truncate. In each case inexact is raised.
- R6: In nearest mode, the truncated value is incremented only when the first discarded bit is set and either a later discarded bit is set or the integer's lowest bit is one.
- R7: For a 32-bit destination, a round-up that carries past bit 31 is invalid, and the result is 0xFFFFFFFF.
- R8: A nonzero magnitude below one gives zero and raises inexact, except in these cases. Toward +inf gives one for a positive operand. Toward -inf on a negative operand gives zero and raises invalid.
- R9: In nearest mode, a magnitude strictly between one half and one gives one if positive, and gives zero with invalid if negative. Exactly one half gives zero with inexact.
- R10: When a raised condition has its trap enabled, `out_trap` is 01 for invalid or 10 for inexact. `out_write` is then low, `out_result` is zero, and the sticky flags do not change. With no trap, `out_trap` is 00 and `out_write` is high.
- R11: An untrapped raised condition sets `flag_invalid` or `flag_inexact` on the acceptance edge. Only reset clears them.
- R12: When invalid is raised, inexact is not reported. It neither sets its flag nor triggers its trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_operand | input | 64 | Floating-point operand (32-bit format in [31:0]) |
| in_src_dbl | input | 1 | 1: 64-bit source format, 0: 32-bit |
| in_dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| in_rmode | input | 2 | Rounding mode |
| in_trap_inv_en | input | 1 | Invalid trap enable |
| in_trap_inx_en | input | 1 | Inexact trap enable |
| out_valid | output | 1 | Result register full |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Integer result |
| out_write | output | 1 | Destination write strobe |
| out_trap | output | 2 | Trap code |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
Every result, write strobe and trap code is due one clock after its acceptance edge. The sticky flags change on that same edge. A scoreboard samples on falling edges, so each comparison sits half a cycle clear of the edge that produced the value. When the consumer never stalls, the bench also checks that each result arrives exactly one cycle after it was accepted. In the stalled phase, the bench only checks the order and content of the results.

// File: rtl/f2u_pkg.sv
`timescale 1ns/1ps
package f2u_pkg;
  localparam int DEXP_W = 11;
  localparam int DMAN_W = 52;
  localparam int SEXP_W = 8;
  localparam int SMAN_W = 23;
  localparam int WIDE_W = 64;
  localparam int NARR_W = 32;
  localparam int OP_W   = 1 + DEXP_W + DMAN_W;
  localparam int SOP_W  = 1 + SEXP_W + SMAN_W;
  localparam int DBIAS  = (1 << (DEXP_W - 1)) - 1;
  localparam int SBIAS  = (1 << (SEXP_W - 1)) - 1;
  localparam int EXP_W  = DEXP_W + 2;
  localparam int SIG_W  = DMAN_W + 1;
  localparam int ALN_W  = WIDE_W + SIG_W;
  localparam int SH_W   = $clog2(WIDE_W + 1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_MINF = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    TRAP_NONE    = 2'b00,
    TRAP_INVALID = 2'b01,
    TRAP_INEXACT = 2'b10
  } trap_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
    logic                    nonzero;
    logic                    frac_nz;
  } fields_t;
endpackage

// File: rtl/f2u_unpack.sv
`timescale 1ns/1ps
module f2u_unpack
  import f2u_pkg::*;
(
  input  logic [OP_W-1:0] operand,
  input  logic            src_dbl,
  output fields_t         fields
);
  logic [DEXP_W-1:0] d_ef;
  logic [DMAN_W-1:0] d_mf;
  logic [SEXP_W-1:0] s_ef;
  logic [SMAN_W-1:0] s_mf;

  assign d_ef = operand[OP_W-2 -: DEXP_W];
  assign d_mf = operand[DMAN_W-1:0];
  assign s_ef = operand[SOP_W-2 -: SEXP_W];
  assign s_mf = operand[SMAN_W-1:0];

  always_comb begin
    if (src_dbl) begin
      fields.sign    = operand[OP_W-1];
      fields.exp     = EXP_W'({{(EXP_W-DEXP_W){1'b0}}, d_ef}) - EXP_W'(DBIAS);
      fields.sig     = {1'b1, d_mf};
      fields.nonzero = |operand[OP_W-2:0];
      fields.frac_nz = |d_mf;
    end else begin
      fields.sign    = operand[SOP_W-1];
      fields.exp     = EXP_W'({{(EXP_W-SEXP_W){1'b0}}, s_ef}) - EXP_W'(SBIAS);
      fields.sig     = {1'b1, s_mf, {(DMAN_W-SMAN_W){1'b0}}};
      fields.nonzero = |operand[SOP_W-2:0];
      fields.frac_nz = |s_mf;
    end
  end
endmodule

// File: rtl/f2u_align.sv
`timescale 1ns/1ps
module f2u_align
  import f2u_pkg::*;
(
  input  logic [SIG_W-1:0]        sig,
  input  logic signed [EXP_W-1:0] exp,
  output logic [WIDE_W-1:0]       int_part,
  output logic                    rnd,
  output logic                    stk
);
  logic            in_span;
  logic [SH_W-1:0] shamt;
  logic [ALN_W-1:0] stage [SH_W+1];

  // integer part sits above SIG_W fraction bits after shifting by exp+1
  assign in_span = (exp >= 0) && (exp < EXP_W'(WIDE_W));
  assign shamt   = in_span ? (exp[SH_W-1:0] + SH_W'(1)) : '0;
  assign stage[0] = {{WIDE_W{1'b0}}, sig};

  for (genvar k = 0; k < SH_W; k++) begin : g_shift
    assign stage[k+1] = shamt[k] ? (stage[k] << (2 ** k)) : stage[k];
  end

  assign int_part = stage[SH_W][ALN_W-1 -: WIDE_W];
  assign rnd      = stage[SH_W][SIG_W-1];
  assign stk      = |stage[SH_W][SIG_W-2:0];
endmodule

// File: rtl/f2u_decide.sv
`timescale 1ns/1ps
module f2u_decide
  import f2u_pkg::*;
(
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] exp,
  input  logic                    nonzero,
  input  logic                    frac_nz,
  input  logic                    dst_wide,
  input  rmode_e                  rmode,
  input  logic [WIDE_W-1:0]       int_part,
  input  logic                    rnd,
  input  logic                    stk,
  output logic [WIDE_W-1:0]       value,
  output logic                    raise_inv,
  output logic                    raise_inx
);
  localparam logic [WIDE_W-1:0] NARR_ONES = WIDE_W'({NARR_W{1'b1}});
  localparam logic [WIDE_W-1:0] WIDE_ONES = {WIDE_W{1'b1}};
  localparam logic [WIDE_W-1:0] ONE       = WIDE_W'(1);

  logic signed [EXP_W-1:0] top_exp;
  logic [WIDE_W-1:0]       dst_ones;
  logic                    frac;
  logic                    bump;
  logic [WIDE_W:0]         summed;
  logic                    carry;

  assign top_exp  = dst_wide ? EXP_W'(WIDE_W - 1) : EXP_W'(NARR_W - 1);
  assign dst_ones = dst_wide ? WIDE_ONES : NARR_ONES;
  assign frac     = rnd | stk;

  always_comb begin
    case (rmode)
      RM_PINF: bump = frac;
      RM_NEAR: bump = rnd & (stk | int_part[0]);
      default: bump = 1'b0;
    endcase
  end

  assign summed = {1'b0, int_part} + {{WIDE_W{1'b0}}, bump};
  assign carry  = dst_wide ? summed[WIDE_W] : summed[NARR_W];

  always_comb begin
    value     = '0;
    raise_inv = 1'b0;
    raise_inx = 1'b0;
    if (exp > top_exp) begin
      raise_inv = 1'b1;
      value     = sign ? '0 : dst_ones;
    end else if (exp >= 0) begin
      if (sign) begin
        raise_inv = 1'b1;
      end else if (carry) begin
        raise_inv = 1'b1;
        value     = dst_ones;
      end else begin
        raise_inx = frac;
        value     = summed[WIDE_W-1:0];
      end
    end else if (nonzero) begin
      raise_inx = 1'b1;
      case (rmode)
        RM_PINF: if (!sign) value = ONE;
        RM_MINF: if (sign) begin
          raise_inv = 1'b1;
          raise_inx = 1'b0;
        end
        RM_NEAR: if (exp == -1 && frac_nz) begin
          if (sign) begin
            raise_inv = 1'b1;
            raise_inx = 1'b0;
          end else begin
            value = ONE;
          end
        end
        default: value = '0;
      endcase
    end
  end
endmodule

// File: rtl/f2u_convert.sv
`timescale 1ns/1ps
module f2u_convert
  import f2u_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_operand,
  input  logic              in_src_dbl,
  input  logic              in_dst_wide,
  input  logic [1:0]        in_rmode,
  input  logic              in_trap_inv_en,
  input  logic              in_trap_inx_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_result,
  output logic              out_write,
  output logic [1:0]        out_trap,
  output logic              flag_invalid,
  output logic              flag_inexact
);
  fields_t           fld;
  logic [WIDE_W-1:0] int_part;
  logic              rnd;
  logic              stk;
  logic [WIDE_W-1:0] value;
  logic              raise_inv;
  logic              raise_inx;
  trap_e             trap_d;
  trap_e             trap_q;
  logic              accept;

  f2u_unpack u_unpack (
    .operand (in_operand),
    .src_dbl (in_src_dbl),
    .fields  (fld)
  );

  f2u_align u_align (
    .sig      (fld.sig),
    .exp      (fld.exp),
    .int_part (int_part),
    .rnd      (rnd),
    .stk      (stk)
  );

  f2u_decide u_decide (
    .sign      (fld.sign),
    .exp       (fld.exp),
    .nonzero   (fld.nonzero),
    .frac_nz   (fld.frac_nz),
    .dst_wide  (in_dst_wide),
    .rmode     (rmode_e'(in_rmode)),
    .int_part  (int_part),
    .rnd       (rnd),
    .stk       (stk),
    .value     (value),
    .raise_inv (raise_inv),
    .raise_inx (raise_inx)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (raise_inv)
      trap_d = in_trap_inv_en ? TRAP_INVALID : TRAP_NONE;
    else if (raise_inx && in_trap_inx_en)
      trap_d = TRAP_INEXACT;
    else
      trap_d = TRAP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_write    <= 1'b0;
      trap_q       <= TRAP_NONE;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_write  <= (trap_d == TRAP_NONE);
      out_result <= (trap_d == TRAP_NONE) ? value : '0;
      trap_q     <= trap_d;
      if (trap_d == TRAP_NONE) begin
        flag_invalid <= flag_invalid | raise_inv;
        flag_inexact <= flag_inexact | raise_inx;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_trap = trap_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_write) && $stable(out_trap));

  assert_trap_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_q != TRAP_NONE |-> !out_write && out_result == '0);

  assert_inv_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);

  assert_inx_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |=> flag_inexact);

  assert_flag_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_invalid) || $rose(flag_inexact) |-> out_valid && out_write);
endmodule

// File: tb/sim_f2u_convert.sv
`timescale 1ns/1ps
module sim_f2u_convert;
  typedef struct packed {
    logic [63:0] res;
    logic        wr;
    logic [1:0]  trap;
    logic        fi;
    logic        fx;
    logic        timed;
    int          acc;
  } exp_t;

  localparam logic [1:0] NEAR = 2'b00, ZERO = 2'b01, PINF = 2'b10, MINF = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic        in_src_dbl = 1'b0;
  logic        in_dst_wide = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        in_trap_inv_en = 1'b0;
  logic        in_trap_inx_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_write;
  logic [1:0]  out_trap;
  logic        flag_invalid;
  logic        flag_inexact;

  exp_t  q[$];
  string tq[$];
  bit    sticky_i, sticky_x, bp_on;
  int    cyc, checks, errors;

  always #2.5 clk = ~clk;

  f2u_convert u0 (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = !bp_on || (cyc % 3 != 0);
  end

  task automatic chk(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic send(input logic [63:0] op, input logic dbl, input logic wide, input logic [1:0] rm,
                      input logic ti, input logic tx, input logic [63:0] val,
                      input logic ri, input logic rx, input string tag);
    exp_t e;
    @(negedge clk);
    in_operand = op; in_src_dbl = dbl; in_dst_wide = wide; in_rmode = rm;
    in_trap_inv_en = ti; in_trap_inx_en = tx; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e.trap = ri ? (ti ? 2'b01 : 2'b00) : ((rx && tx) ? 2'b10 : 2'b00);
    e.wr   = (e.trap == 2'b00);
    e.res  = e.wr ? val : 64'd0;
    if (e.wr) begin
      sticky_i |= ri;
      sticky_x |= rx;
    end
    e.fi = sticky_i; e.fx = sticky_x; e.timed = !bp_on; e.acc = cyc;
    q.push_back(e);
    tq.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: compare results when they transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected output", {out_result, out_write, out_trap, flag_invalid, flag_inexact}, '0);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        chk({out_result, out_write, out_trap, flag_invalid, flag_inexact} == {e.res, e.wr, e.trap, e.fi, e.fx},
            t, {out_result, out_write, out_trap, flag_invalid, flag_inexact}, {e.res, e.wr, e.trap, e.fi, e.fx});
        if (e.timed)
          chk(cyc == e.acc + 1, "R1 latency one cycle", 69'(cyc), 69'(e.acc + 1));
      end
    end
  end

  task automatic drain();
    for (int g = 0; g < 200 && q.size() != 0; g++) @(negedge clk);
    chk(q.size() == 0, "R1 all results delivered", 69'(q.size()), 69'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sticky_i = 0; sticky_x = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", 69'(out_valid), 69'd0);
    chk(in_ready == 1'b1, "R1 reset in_ready", 69'(in_ready), 69'd1);
    chk({flag_invalid, flag_inexact} == 2'b00, "R11 reset flags", 69'({flag_invalid, flag_inexact}), 69'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    do_reset();
    // exact conversions, flags must stay clear
    send(64'h40400000, 0, 0, NEAR, 0, 0, 64'd3, 0, 0, "R4 3.0 single to 32");
    send(64'h3FF0000000000000, 1, 1, NEAR, 0, 0, 64'd1, 0, 0, "R4 1.0 double to 64");
    send(64'h43E0000000000000, 1, 1, ZERO, 0, 0, 64'h8000000000000000, 0, 0, "R4 2^63 double to 64");
    send(64'h43EFFFFFFFFFFFFF, 1, 1, NEAR, 0, 0, 64'hFFFFFFFFFFFFF800, 0, 0, "R4 largest below 2^64");
    send(64'hFFFFFFFF4F800000, 0, 1, NEAR, 0, 0, 64'h100000000, 0, 0, "R4 2^32 single to 64, upper operand bits ignored");
    send(64'h00000000, 0, 0, MINF, 0, 0, 64'd0, 0, 0, "R4 +0.0 exact");
    send(64'h80000000, 0, 0, MINF, 0, 0, 64'd0, 0, 0, "R8 -0.0 exact");
    // rounding
    send(64'h40200000, 0, 0, NEAR, 0, 0, 64'd2, 0, 1, "R6 2.5 tie to even down");
    send(64'h40600000, 0, 0, NEAR, 0, 0, 64'd4, 0, 1, "R6 3.5 tie to even up");
    send(64'h40300000, 0, 0, NEAR, 0, 0, 64'd3, 0, 1, "R6 2.75 above half");
    send(64'h40200000, 0, 0, PINF, 0, 0, 64'd3, 0, 1, "R5 2.5 toward +inf");
    send(64'h40200000, 0, 0, ZERO, 0, 0, 64'd2, 0, 1, "R5 2.5 toward zero");
    send(64'h40200000, 0, 0, MINF, 0, 0, 64'd2, 0, 1, "R5 2.5 toward -inf");
    // invalid paths
    send(64'hBF800000, 0, 0, NEAR, 0, 0, 64'd0, 1, 0, "R3 -1.0 invalid");
    send(64'h4F800000, 0, 0, NEAR, 0, 0, 64'hFFFFFFFF, 1, 0, "R2 2^32 into 32 bits");
    send(64'hCF800000, 0, 0, NEAR, 0, 0, 64'd0, 1, 0, "R2 -2^32 into 32 bits");
    send(64'h7F800000, 0, 1, NEAR, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0, "R2 +inf into 64 bits");
    send(64'h7FC00000, 0, 0, ZERO, 0, 0, 64'hFFFFFFFF, 1, 0, "R2 NaN into 32 bits");
    send(64'h43F0000000000000, 1, 1, NEAR, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0, "R2 2^64 double into 64");
    send(64'h41EFFFFFFFF00000, 1, 0, NEAR, 0, 0, 64'hFFFFFFFF, 1, 0, "R7 carry out of 32 bits");
    send(64'h41EFFFFFFFF00000, 1, 0, ZERO, 0, 0, 64'hFFFFFFFF, 0, 1, "R5 2^32-0.5 toward zero");
    send(64'h41EFFFFFFFF00000, 1, 1, NEAR, 0, 0, 64'h100000000, 0, 1, "R6 2^32-0.5 into 64 bits");
    // below one
    send(64'h3F400000, 0, 0, NEAR, 0, 0, 64'd1, 0, 1, "R9 0.75 nearest");
    send(64'hBF400000, 0, 0, NEAR, 0, 0, 64'd0, 1, 0, "R9 -0.75 nearest invalid");
    send(64'h3F000000, 0, 0, NEAR, 0, 0, 64'd0, 0, 1, "R9 exactly 0.5");
    send(64'h3E800000, 0, 0, PINF, 0, 0, 64'd1, 0, 1, "R8 0.25 toward +inf");
    send(64'hBE800000, 0, 0, MINF, 0, 0, 64'd0, 1, 0, "R8 -0.25 toward -inf invalid");
    send(64'hBE800000, 0, 0, PINF, 0, 0, 64'd0, 0, 1, "R8 -0.25 toward +inf");
    send(64'h3F400000, 0, 0, ZERO, 0, 0, 64'd0, 0, 1, "R8 0.75 toward zero");
    send(64'h00000001, 0, 1, PINF, 0, 0, 64'd1, 0, 1, "R8 denormal toward +inf");
    drain();

    // traps from a clean flag state
    do_reset();
    send(64'h40200000, 0, 0, ZERO, 0, 1, 64'd2, 0, 1, "R10 inexact trap");
    send(64'hBF800000, 0, 0, NEAR, 1, 0, 64'd0, 1, 0, "R10 invalid trap");
    send(64'h41EFFFFFFFF00000, 1, 0, NEAR, 1, 1, 64'hFFFFFFFF, 1, 0, "R10 overflow trapped as invalid");
    send(64'hBF400000, 0, 0, NEAR, 0, 1, 64'd0, 1, 0, "R12 invalid wins over inexact trap");
    send(64'h41EFFFFFFFF00000, 1, 0, NEAR, 0, 1, 64'hFFFFFFFF, 1, 0, "R12 overflow without inexact");
    send(64'h40400000, 0, 0, NEAR, 0, 0, 64'd3, 0, 0, "R11 invalid flag stays set");
    drain();

    // back-pressure phase
    bp_on = 1;
    send(64'h40400000, 0, 0, NEAR, 0, 0, 64'd3, 0, 0, "R1 stalled 3.0");
    send(64'h40600000, 0, 0, NEAR, 0, 0, 64'd4, 0, 1, "R1 stalled 3.5");
    send(64'h40200000, 0, 0, PINF, 0, 0, 64'd3, 0, 1, "R1 stalled 2.5 up");
    send(64'h4F800000, 0, 0, NEAR, 0, 0, 64'hFFFFFFFF, 1, 0, "R1 stalled out of range");
    send(64'h3F400000, 0, 0, NEAR, 0, 0, 64'd1, 0, 1, "R1 stalled 0.75");
    send(64'h3E800000, 0, 0, PINF, 0, 0, 64'd1, 0, 1, "R1 stalled 0.25 up");
    send(64'h43E0000000000000, 1, 1, ZERO, 0, 0, 64'h8000000000000000, 0, 0, "R1 stalled 2^63");
    drain();
    bp_on = 0;

    report();
    $finish;
  end
endmodule